// File: doc/BRIEF.md
# Paired Byte/Word General Register File

This block stores six 8-bit general registers that software-visible logic can address either one byte at a time or as three 16-bit pairs. The pairs are named BC, DE and HL; in each pair the first-named register (B, D, H) is the high byte. Two combinational byte read ports and one byte write port serve 8-bit traffic. A combinational pair read port and a pair write port serve 16-bit traffic. A register-to-register byte copy is done by feeding byte read port A into the byte write port in the same cycle.

Two wide operations act directly on the storage. The first is a one-cycle swap of the DE and HL pairs. The second is a 16-bit add of BC, DE, HL or an external stack-pointer operand into HL, with the carry out of bit 15 held on a flag output. The HL pair is driven at all times on a 16-bit address output, which surrounding logic uses as the pointer for the memory operand that stands in for an eighth "register".

Top module: `pair_regfile`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) clears all six registers and the carry flag to zero.
- R2: Each byte read port returns, without a clock delay, the register chosen by its 3-bit select: B=0, C=1, D=2, E=3, H=4, L=5. Codes 6 (memory operand) and 7 (reserved) read as zero.
- R3: A byte write with wr_en_i high and a select of 0 to 5 loads only the selected byte. Codes 6 and 7 change no register.
- R4: The pair read port returns the pair chosen by its 2-bit select: BC=0, DE=1, HL=2. The high byte of the pair is in bits 15:8. Select 3 returns sp_i.
- R5: A pair write with select 0 to 2 loads both bytes of that pair. Select 3 changes no register. When a pair write and a byte write target the same pair in one cycle, the pair write wins.
- R6: addr_o always equals the current HL value.
- R7: An exchange (xchg_en_i) swaps DE with HL in one cycle, so that H and D trade places and L and E trade places.
- R8: An add (add_en_i) loads HL with HL plus the operand chosen by add_sel_i (BC=0, DE=1, HL=2, sp_i=3). carry_o takes bit 16 of the sum. carry_o keeps its value in every cycle without an add, and is the only status the block produces.
- R9: Adding HL to itself leaves HL shifted left by one bit, with the old bit 15 on carry_o.
- R10: An add takes priority over an exchange, and the exchange is then dropped. An add or an exchange takes priority over pair writes and byte writes to the pairs it loads.
- R11: A byte copy of a register onto itself leaves every register unchanged. A copy between two different registers loads the destination with the source value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rd_a_sel_i | input | 3 | Byte read port A select |
| rd_a_data_o | output | 8 | Byte read port A data |
| rd_b_sel_i | input | 3 | Byte read port B select |
| rd_b_data_o | output | 8 | Byte read port B data |
| wr_en_i | input | 1 | Byte write enable |
| wr_sel_i | input | 3 | Byte write select |
| wr_data_i | input | 8 | Byte write data |
| prd_sel_i | input | 2 | Pair read select |
| prd_data_o | output | 16 | Pair read data |
| pwr_en_i | input | 1 | Pair write enable |
| pwr_sel_i | input | 2 | Pair write select |
| pwr_data_i | input | 16 | Pair write data |
| xchg_en_i | input | 1 | Swap DE and HL |
| add_en_i | input | 1 | Add selected operand into HL |
| add_sel_i | input | 2 | Add operand select |
| sp_i | input | 16 | External stack-pointer operand |
| addr_o | output | 16 | HL presented as memory pointer |
| carry_o | output | 1 | Carry out of the last 16-bit add |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions: add against exchange, exchange against a pair write, and a pair write against a byte write into the same pair. Normal use rarely raises two of these commands at once. The bench drives each pair of commands in a single cycle from known register contents, then reads every pair back. The carry path at bit 16 is reached by loading values whose sum overflows: a self-add with bit 15 set, and an add of a large stack-pointer value. A carry that stays stable across the cycles without an add is checked after unrelated writes.

// File: rtl/prf_pkg.sv
package prf_pkg;
   localparam int unsigned PAIR_CNT = 3;
   localparam int unsigned SEL_W    = 3;
   localparam int unsigned PSEL_W   = 2;
   localparam int unsigned IDX_BC   = 0;
   localparam int unsigned IDX_DE   = 1;
   localparam int unsigned IDX_HL   = 2;
   localparam logic [PSEL_W-1:0] PSEL_SP = 2'd3;
endpackage

// File: rtl/prf_byte_read.sv
module prf_byte_read
   import prf_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [PAIR_CNT-1:0][2*BYTE_W-1:0] pairs_i,
   input  logic [SEL_W-1:0]                  sel_i,
   output logic [BYTE_W-1:0]                 data_o
);
   always_comb begin
      data_o = '0;
      for (int p = 0; p < int'(PAIR_CNT); p++) begin
         if (sel_i == SEL_W'(2*p))     data_o = pairs_i[p][2*BYTE_W-1:BYTE_W];
         if (sel_i == SEL_W'(2*p + 1)) data_o = pairs_i[p][BYTE_W-1:0];
      end
   end
endmodule

// File: rtl/prf_pair_cell.sv
module prf_pair_cell #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  load_i,
   input  logic [2*BYTE_W-1:0]   load_val_i,
   input  logic                  hi_we_i,
   input  logic                  lo_we_i,
   input  logic [BYTE_W-1:0]     byte_i,
   output logic [2*BYTE_W-1:0]   q_o
);
   logic [BYTE_W-1:0] hi_q, lo_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (load_i) begin
         hi_q <= load_val_i[2*BYTE_W-1:BYTE_W];
         lo_q <= load_val_i[BYTE_W-1:0];
      end else begin
         if (hi_we_i) hi_q <= byte_i;
         if (lo_we_i) lo_q <= byte_i;
      end
   end

   assign q_o = {hi_q, lo_q};
endmodule

// File: rtl/prf_wide_add.sv
module prf_wide_add #(
   parameter int unsigned W        = 16,
   parameter bit          SPLIT_ADD = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o
);
   localparam int unsigned LO_W = W / 2;
   localparam int unsigned HI_W = W - LO_W;

   if (W < 2) begin : g_bad_width
      $error("prf_wide_add: W must be at least 2");
   end

   if (SPLIT_ADD) begin : g_split
      logic [LO_W:0] lo_s;
      logic [HI_W:0] hi_s;
      assign lo_s    = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_i[LO_W-1:0]};
      assign hi_s    = {1'b0, a_i[W-1:LO_W]} + {1'b0, b_i[W-1:LO_W]} + (HI_W+1)'(lo_s[LO_W]);
      assign sum_o   = {hi_s[HI_W-1:0], lo_s[LO_W-1:0]};
      assign carry_o = hi_s[HI_W];
   end else begin : g_flat
      logic [W:0] s;
      assign s       = {1'b0, a_i} + {1'b0, b_i};
      assign sum_o   = s[W-1:0];
      assign carry_o = s[W];
   end
endmodule

// File: rtl/pair_regfile.sv
module pair_regfile
   import prf_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter bit          SPLIT_ADD = 1'b0
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [2:0]          rd_a_sel_i,
   output logic [BYTE_W-1:0]   rd_a_data_o,
   input  logic [2:0]          rd_b_sel_i,
   output logic [BYTE_W-1:0]   rd_b_data_o,
   input  logic                wr_en_i,
   input  logic [2:0]          wr_sel_i,
   input  logic [BYTE_W-1:0]   wr_data_i,
   input  logic [1:0]          prd_sel_i,
   output logic [2*BYTE_W-1:0] prd_data_o,
   input  logic                pwr_en_i,
   input  logic [1:0]          pwr_sel_i,
   input  logic [2*BYTE_W-1:0] pwr_data_i,
   input  logic                xchg_en_i,
   input  logic                add_en_i,
   input  logic [1:0]          add_sel_i,
   input  logic [2*BYTE_W-1:0] sp_i,
   output logic [2*BYTE_W-1:0] addr_o,
   output logic                carry_o
);
   localparam int unsigned PW = 2 * BYTE_W;

   if (BYTE_W < 2) begin : g_bad_byte
      $error("pair_regfile: BYTE_W must be at least 2");
   end

   logic [PAIR_CNT-1:0][PW-1:0] pair_q;
   logic [PW-1:0] add_op, add_sum;
   logic          add_c, carry_q, xchg_eff;

   assign xchg_eff = xchg_en_i & ~add_en_i;

   always_comb begin
      unique case (add_sel_i)
         2'd0:    add_op = pair_q[IDX_BC];
         2'd1:    add_op = pair_q[IDX_DE];
         2'd2:    add_op = pair_q[IDX_HL];
         default: add_op = sp_i;
      endcase
   end

   always_comb begin
      unique case (prd_sel_i)
         2'd0:    prd_data_o = pair_q[IDX_BC];
         2'd1:    prd_data_o = pair_q[IDX_DE];
         2'd2:    prd_data_o = pair_q[IDX_HL];
         default: prd_data_o = sp_i;
      endcase
   end

   prf_wide_add #(.W(PW), .SPLIT_ADD(SPLIT_ADD)) add_i (
      .a_i(pair_q[IDX_HL]), .b_i(add_op), .sum_o(add_sum), .carry_o(add_c)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i)         carry_q <= 1'b0;
      else if (add_en_i) carry_q <= add_c;
   end

   for (genvar p = 0; p < int'(PAIR_CNT); p++) begin : g_pair
      logic          add_hit, xch_hit, pw_hit, load, hi_we, lo_we;
      logic [PW-1:0] load_val;

      assign add_hit = add_en_i && (p == int'(IDX_HL));
      assign xch_hit = xchg_eff && (p == int'(IDX_DE) || p == int'(IDX_HL));
      assign pw_hit  = pwr_en_i && (pwr_sel_i == PSEL_W'(p));
      assign load    = add_hit | xch_hit | pw_hit;
      assign load_val = add_hit ? add_sum :
                        xch_hit ? ((p == int'(IDX_DE)) ? pair_q[IDX_HL] : pair_q[IDX_DE]) :
                        pwr_data_i;
      assign hi_we = wr_en_i && (wr_sel_i == SEL_W'(2*p));
      assign lo_we = wr_en_i && (wr_sel_i == SEL_W'(2*p + 1));

      prf_pair_cell #(.BYTE_W(BYTE_W)) cell_i (
         .clk_i(clk_i), .rst_i(rst_i), .load_i(load), .load_val_i(load_val),
         .hi_we_i(hi_we), .lo_we_i(lo_we), .byte_i(wr_data_i), .q_o(pair_q[p])
      );
   end

   prf_byte_read #(.BYTE_W(BYTE_W)) rda_i (
      .pairs_i(pair_q), .sel_i(rd_a_sel_i), .data_o(rd_a_data_o)
   );
   prf_byte_read #(.BYTE_W(BYTE_W)) rdb_i (
      .pairs_i(pair_q), .sel_i(rd_b_sel_i), .data_o(rd_b_data_o)
   );

   assign addr_o  = pair_q[IDX_HL];
   assign carry_o = carry_q;
endmodule

// File: rtl/pair_regfile_chk.sv
module pair_regfile_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic                clk_i,
   input logic                rst_i,
   input logic                wr_en_i,
   input logic [2:0]          wr_sel_i,
   input logic [1:0]          prd_sel_i,
   input logic [2*BYTE_W-1:0] prd_data_o,
   input logic                pwr_en_i,
   input logic [1:0]          pwr_sel_i,
   input logic [2*BYTE_W-1:0] pwr_data_i,
   input logic                xchg_en_i,
   input logic                add_en_i,
   input logic [1:0]          add_sel_i,
   input logic [2*BYTE_W-1:0] sp_i,
   input logic [2*BYTE_W-1:0] addr_o,
   input logic                carry_o,
   input logic [2*BYTE_W-1:0] bc_q,
   input logic [2*BYTE_W-1:0] de_q,
   input logic [2*BYTE_W-1:0] hl_q
);
   localparam int unsigned PW = 2 * BYTE_W;
   logic [PW-1:0] exp_op;

   always_comb begin
      case (add_sel_i)
         2'd0:    exp_op = bc_q;
         2'd1:    exp_op = de_q;
         2'd2:    exp_op = hl_q;
         default: exp_op = sp_i;
      endcase
   end

   assert_reset_clears_R1: assert property (@(posedge clk_i)
      rst_i |=> (bc_q == '0 && de_q == '0 && hl_q == '0 && !carry_o));

   assert_sp_read_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (prd_sel_i == 2'd3) |-> (prd_data_o == sp_i));

   assert_pair_beats_byte_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (pwr_en_i && pwr_sel_i == 2'd0 && wr_en_i && wr_sel_i <= 3'd1) |=> (bc_q == $past(pwr_data_i)));

   assert_sp_write_ignored_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (pwr_en_i && pwr_sel_i == 2'd3 && !wr_en_i && !add_en_i && !xchg_en_i)
      |=> ($stable(bc_q) && $stable(de_q) && $stable(hl_q)));

   assert_addr_is_hl_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (prd_sel_i == 2'd2) |-> (prd_data_o == addr_o));

   assert_exchange_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (xchg_en_i && !add_en_i) |=> (de_q == $past(hl_q) && hl_q == $past(de_q)));

   assert_add_sum_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      add_en_i |=> ({carry_o, hl_q} == ({1'b0, $past(hl_q)} + {1'b0, $past(exp_op)})));

   assert_carry_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !add_en_i |=> $stable(carry_o));

   assert_self_add_shift_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (add_en_i && add_sel_i == 2'd2)
      |=> (hl_q == {$past(hl_q[PW-2:0]), 1'b0} && carry_o == $past(hl_q[PW-1])));

   assert_add_beats_xchg_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (add_en_i && xchg_en_i && !(pwr_en_i && pwr_sel_i == 2'd1) && !(wr_en_i && (wr_sel_i == 3'd2 || wr_sel_i == 3'd3)))
      |=> $stable(de_q));
endmodule

bind pair_regfile pair_regfile_chk #(.BYTE_W(BYTE_W)) chk_i (
   .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
   .prd_sel_i(prd_sel_i), .prd_data_o(prd_data_o), .pwr_en_i(pwr_en_i),
   .pwr_sel_i(pwr_sel_i), .pwr_data_i(pwr_data_i), .xchg_en_i(xchg_en_i),
   .add_en_i(add_en_i), .add_sel_i(add_sel_i), .sp_i(sp_i), .addr_o(addr_o),
   .carry_o(carry_o), .bc_q(pair_q[0]), .de_q(pair_q[1]), .hl_q(pair_q[2])
);

// File: tb/pair_regfile_tb_top.sv
module pair_regfile_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk_i = 1'b0;
   logic        rst_i = 1'b1;
   logic [2:0]  rd_a_sel_i = '0, rd_b_sel_i = '0, wr_sel_i = '0;
   logic [7:0]  rd_a_data_o, rd_b_data_o, wr_data_i = '0;
   logic        wr_en_i = 1'b0, pwr_en_i = 1'b0, xchg_en_i = 1'b0, add_en_i = 1'b0;
   logic [1:0]  prd_sel_i = '0, pwr_sel_i = '0, add_sel_i = '0;
   logic [15:0] prd_data_o, pwr_data_i = '0, addr_o;
   logic [15:0] sp_i = 16'h8400;
   logic        carry_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk_i = ~clk_i;

   pair_regfile dut_i (.*);

   // vector: kind(3) sel(3) data(16) chk_pair(2) exp(16) carry(1)
   // kind 0 byte write, 1 pair write, 2 exchange, 3 add, 4 idle
   localparam int NV = 14;
   localparam logic [40:0] VEC [NV] = '{
      {3'd1, 3'd0, 16'h1234, 2'd0, 16'h1234, 1'b0},
      {3'd1, 3'd1, 16'hABCD, 2'd1, 16'hABCD, 1'b0},
      {3'd1, 3'd2, 16'h8001, 2'd2, 16'h8001, 1'b0},
      {3'd0, 3'd1, 16'h005A, 2'd0, 16'h125A, 1'b0},
      {3'd0, 3'd4, 16'h007F, 2'd2, 16'h7F01, 1'b0},
      {3'd0, 3'd6, 16'h00EE, 2'd2, 16'h7F01, 1'b0},
      {3'd2, 3'd0, 16'h0000, 2'd2, 16'hABCD, 1'b0},
      {3'd4, 3'd0, 16'h0000, 2'd1, 16'h7F01, 1'b0},
      {3'd3, 3'd0, 16'h0000, 2'd2, 16'hBE27, 1'b0},
      {3'd3, 3'd2, 16'h0000, 2'd2, 16'h7C4E, 1'b1},
      {3'd4, 3'd0, 16'h0000, 2'd0, 16'h125A, 1'b1},
      {3'd3, 3'd3, 16'h0000, 2'd2, 16'h004E, 1'b1},
      {3'd3, 3'd1, 16'h0000, 2'd2, 16'h7F4F, 1'b0},
      {3'd1, 3'd3, 16'hFFFF, 2'd0, 16'h125A, 1'b0}
   };
   localparam string VREQ [NV] = '{"R5", "R5", "R5", "R3", "R3", "R3", "R7", "R7",
                                    "R8", "R9", "R8", "R8", "R8", "R5"};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_pair(input logic [1:0] sel, output logic [15:0] val);
      prd_sel_i = sel;
      #0.5;
      val = prd_data_o;
   endtask

   task automatic check_all(input string req, input logic [15:0] bc, input logic [15:0] de,
                            input logic [15:0] hl);
      logic [15:0] v;
      read_pair(2'd0, v); check(req, 32'(v), 32'(bc));
      read_pair(2'd1, v); check(req, 32'(v), 32'(de));
      read_pair(2'd2, v); check(req, 32'(v), 32'(hl));
   endtask

   task automatic tick();
      @(posedge clk_i);
      #0.5;
      wr_en_i = 1'b0; pwr_en_i = 1'b0; xchg_en_i = 1'b0; add_en_i = 1'b0;
   endtask

   initial begin
      logic [15:0] v;
      repeat (3) @(posedge clk_i);
      #0.5 rst_i = 1'b0;
      // R1: reset state
      check_all("R1", 16'h0000, 16'h0000, 16'h0000);
      check("R1", 32'(carry_o), 32'd0);
      check("R6", 32'(addr_o), 32'h0000);

      for (int i = 0; i < NV; i++) begin
         logic [40:0] vv;
         vv = VEC[i];
         @(negedge clk_i);
         case (vv[40:38])
            3'd0: begin wr_en_i = 1'b1; wr_sel_i = vv[37:35]; wr_data_i = vv[26:19]; end
            3'd1: begin pwr_en_i = 1'b1; pwr_sel_i = vv[36:35]; pwr_data_i = vv[34:19]; end
            3'd2: xchg_en_i = 1'b1;
            3'd3: begin add_en_i = 1'b1; add_sel_i = vv[36:35]; end
            default: ;
         endcase
         tick();
         read_pair(vv[18:17], v);
         check(VREQ[i], 32'(v), 32'(vv[16:1]));
         check("R8", 32'(carry_o), 32'(vv[0]));
      end

      // State: BC=125A DE=7F01 HL=7F4F carry=0
      rd_a_sel_i = 3'd0; rd_b_sel_i = 3'd5; #0.5;
      check("R2", 32'(rd_a_data_o), 32'h12);
      check("R2", 32'(rd_b_data_o), 32'h4F);
      rd_a_sel_i = 3'd6; rd_b_sel_i = 3'd7; #0.5;
      check("R2", 32'(rd_a_data_o), 32'h00);
      check("R2", 32'(rd_b_data_o), 32'h00);
      rd_b_sel_i = 3'd3; #0.5;
      check("R2", 32'(rd_b_data_o), 32'h01);
      check("R6", 32'(addr_o), 32'h7F4F);
      read_pair(2'd3, v); check("R4", 32'(v), 32'h8400);

      // R5: pair write and byte write to HL together
      @(negedge clk_i);
      pwr_en_i = 1'b1; pwr_sel_i = 2'd2; pwr_data_i = 16'h1111;
      wr_en_i = 1'b1; wr_sel_i = 3'd4; wr_data_i = 8'h99;
      tick();
      check_all("R5", 16'h125A, 16'h7F01, 16'h1111);

      // R10: add together with exchange, exchange dropped
      @(negedge clk_i);
      add_en_i = 1'b1; add_sel_i = 2'd0; xchg_en_i = 1'b1;
      tick();
      check_all("R10", 16'h125A, 16'h7F01, 16'h236B);
      check("R10", 32'(carry_o), 32'd0);

      // R10: exchange beats a pair write to HL
      @(negedge clk_i);
      xchg_en_i = 1'b1; pwr_en_i = 1'b1; pwr_sel_i = 2'd2; pwr_data_i = 16'hAAAA;
      tick();
      check_all("R10", 16'h125A, 16'h236B, 16'h7F01);

      // R11: copy E onto itself
      @(negedge clk_i);
      rd_a_sel_i = 3'd3; #0.5;
      wr_en_i = 1'b1; wr_sel_i = 3'd3; wr_data_i = rd_a_data_o;
      tick();
      check_all("R11", 16'h125A, 16'h236B, 16'h7F01);

      // R11: copy D into L
      @(negedge clk_i);
      rd_a_sel_i = 3'd2; #0.5;
      wr_en_i = 1'b1; wr_sel_i = 3'd5; wr_data_i = rd_a_data_o;
      tick();
      check_all("R11", 16'h125A, 16'h236B, 16'h7F23);

      // R3: reserved code 7 writes nothing
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_sel_i = 3'd7; wr_data_i = 8'h55;
      tick();
      check_all("R3", 16'h125A, 16'h236B, 16'h7F23);

      // R8: stack-pointer add with carry out
      @(negedge clk_i);
      add_en_i = 1'b1; add_sel_i = 2'd3;
      tick();
      check_all("R8", 16'h125A, 16'h236B, 16'h0323);
      check("R8", 32'(carry_o), 32'd1);

      // R1: reset in mid-run
      @(negedge clk_i);
      rst_i = 1'b1;
      @(posedge clk_i);
      #0.5 rst_i = 1'b0;
      check_all("R1", 16'h0000, 16'h0000, 16'h0000);
      check("R1", 32'(carry_o), 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule